// File: doc/BRIEF.md
# Load Result Shaper

This block sits between the memory read return and the register write port of a load pipeline. It takes a 128-bit read word plus four control fields and produces the 64-bit value that a load instruction writes into its target register. The controls are the access size, a sign-extension request, a byte-swap request and the current endian mode. A quadword load produces two 64-bit values, one for the even register and one for the odd register of a register pair. Address generation, memory access and alignment checks happen elsewhere.

Zero versus sign extension, byte-order reversal and quadword pair ordering all share one combinational data path. Both 64-bit halves of the read word pass through byte reversers. A small size-driven shift then narrows the lower reversed half for halfword and word swaps, and a single extension stage finishes the result.

Control combinations that no load instruction can produce are flagged, and their results are forced to zero. A parameter selects one of two output timings:
- the results leave straight from the combinational path; or
- they are captured in an output register that adds one cycle of latency.

Bit numbering: the block numbers bits with the least significant bit as 0. A byte load therefore fills bits 7..0, which are bits 56..63 in most-significant-first numbering. The read word is laid out so that the lower-address doubleword occupies `mem_data_i[127:64]` and the doubleword at address+8 occupies `mem_data_i[63:0]`. For accesses narrower than 16 bytes, the element sits in the least significant bytes of `mem_data_i`.

Top module: `ldf_load_shaper`

## Requirements
- R1: With size code 0 (1 byte), 1 (2 bytes) or 2 (4 bytes), `alg_i`=0 and `brev_i`=0, `res_even_o` holds `mem_data_i` bits 7..0, 15..0 or 31..0 respectively in its low bits, and every bit above them is 0.
- R2: With size code 1 or 2, `alg_i`=1 and `brev_i`=0, `res_even_o` holds the low 16 or 32 bits of `mem_data_i`, and every upper bit is a copy of bit 15 or bit 31 of `mem_data_i`.
- R3: With size code 3 (8 bytes), `alg_i`=0 and `brev_i`=0, `res_even_o` equals `mem_data_i[63:0]`.
- R4: With size code 1, `brev_i`=1 and `alg_i`=0, `res_even_o` equals {48 zero bits, `mem_data_i[7:0]`, `mem_data_i[15:8]`}.
- R5: With size code 2, `brev_i`=1 and `alg_i`=0, `res_even_o` holds 32 zero bits followed by bytes 0, 1, 2 and 3 of `mem_data_i`, from most to least significant. Byte k is bits 8k+7..8k.
- R6: With size code 3, `brev_i`=1 and `alg_i`=0, `res_even_o` holds bytes 0 through 7 of `mem_data_i`, from most to least significant.
- R7: With size code 4 (16 bytes), `alg_i`=0, `brev_i`=0 and `le_mode_i`=0 (big-endian), `res_even_o` equals `mem_data_i[127:64]` and `res_odd_o` equals `mem_data_i[63:0]`.
- R8: With size code 4, `alg_i`=0, `brev_i`=0 and `le_mode_i`=1 (little-endian), `res_even_o` is the byte-reversed `mem_data_i[63:0]` and `res_odd_o` is the byte-reversed `mem_data_i[127:64]`.
- R9: For every size code other than 4, `res_odd_o` is 0 and `le_mode_i` has no effect on `res_even_o`.
- R10: `illegal_o` is 1, and both results are 0, exactly in these cases:
  - `brev_i`=1 together with `alg_i`=1;
  - `brev_i`=1 with size code 0 or 4;
  - `alg_i`=1 with size code 0, 3 or 4;
  - size codes 5, 6 and 7.

  In every other case `illegal_o` is 0.
- R11: With `OUT_REG`=1, the outputs appear one clock after the inputs and are cleared to 0 while `rst_n` is low. With `OUT_REG`=0, they follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data_i | input | 128 | Read data; lower-address doubleword in the upper half |
| size_i | input | 3 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B, 4=16B |
| alg_i | input | 1 | Sign-extend the loaded element |
| brev_i | input | 1 | Reverse the byte order of the loaded element |
| le_mode_i | input | 1 | 1 selects little-endian pair ordering for quadword loads |
| res_even_o | output | 64 | Result for ordinary loads; even register of a quadword pair |
| res_odd_o | output | 64 | Odd register of a quadword pair; 0 otherwise |
| illegal_o | output | 1 | Control combination not allowed |

## Verification
The bench builds two copies of the block.
- One copy has `OUT_REG`=1. On this copy the bench checks the one-cycle latency and the asynchronous clear during reset and in the middle of a run.
- The other copy has `OUT_REG`=0. On this copy the same vectors show that the purely combinational variant settles with no clock.

Both copies receive the same table of vectors. The table uses two read patterns:
- in the first, the element sign bits are set;
- in the second, the halfword is positive and the word is negative.

Together these reach both extension polarities, every reversal width, both quadword orderings and each illegal combination.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
    localparam int XLEN   = 64;
    localparam int QW     = 2 * XLEN;
    localparam int NBYTES = XLEN / 8;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_QUAD = 3'd4
    } size_e;

    typedef struct packed {
        logic [XLEN-1:0] even;
        logic [XLEN-1:0] odd;
        logic            illegal;
    } result_t;
endpackage

// File: rtl/ldf_byte_rev.sv
module ldf_byte_rev #(
    parameter int NB = 8
) (
    input  logic [NB*8-1:0] data_i,
    output logic [NB*8-1:0] data_o
);
    // Byte lane g of the output takes lane NB-1-g of the input.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign data_o[g*8 +: 8] = data_i[(NB-1-g)*8 +: 8];
    end
endmodule

// File: rtl/ldf_legal.sv
module ldf_legal
    import ldf_pkg::*;
(
    input  logic [2:0] size_i,
    input  logic       alg_i,
    input  logic       brev_i,
    output logic       illegal_o
);
    always_comb begin
        case (size_i)
            SZ_BYTE:          illegal_o = alg_i | brev_i;
            SZ_HALF, SZ_WORD: illegal_o = alg_i & brev_i;
            SZ_DBL:           illegal_o = alg_i;
            SZ_QUAD:          illegal_o = alg_i | brev_i;
            default:          illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/ldf_extend.sv
module ldf_extend
    import ldf_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] elem_i,
    input  logic [2:0]   size_i,
    input  logic         sign_i,
    output logic [W-1:0] val_o
);
    localparam int HB = 16;
    localparam int WB = 32;

    always_comb begin
        case (size_i)
            SZ_BYTE: val_o = {{(W-8){sign_i & elem_i[7]}},     elem_i[7:0]};
            SZ_HALF: val_o = {{(W-HB){sign_i & elem_i[HB-1]}}, elem_i[HB-1:0]};
            SZ_WORD: val_o = {{(W-WB){sign_i & elem_i[WB-1]}}, elem_i[WB-1:0]};
            default: val_o = elem_i;
        endcase
    end
endmodule

// File: rtl/ldf_load_shaper.sv
module ldf_load_shaper
    import ldf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [QW-1:0]   mem_data_i,
    input  logic [2:0]      size_i,
    input  logic            alg_i,
    input  logic            brev_i,
    input  logic            le_mode_i,
    output logic [XLEN-1:0] res_even_o,
    output logic [XLEN-1:0] res_odd_o,
    output logic            illegal_o
);
    localparam int HSHIFT = XLEN - 16;
    localparam int WSHIFT = XLEN - 32;

    logic [XLEN-1:0] lo_dw, hi_dw, lo_rev, hi_rev;
    logic [XLEN-1:0] swap_elem, elem, ext_val;
    logic            illegal;
    result_t         res_d, res_q;

    assign lo_dw = mem_data_i[XLEN-1:0];
    assign hi_dw = mem_data_i[QW-1:XLEN];

    ldf_byte_rev #(.NB(NBYTES)) u_rev_lo (.data_i(lo_dw), .data_o(lo_rev));
    ldf_byte_rev #(.NB(NBYTES)) u_rev_hi (.data_i(hi_dw), .data_o(hi_rev));

    ldf_legal u_legal (
        .size_i   (size_i),
        .alg_i    (alg_i),
        .brev_i   (brev_i),
        .illegal_o(illegal)
    );

    // A narrow swapped element ends up at the top of the reversed doubleword;
    // shift it down so the extension stage sees it in the low lanes.
    always_comb begin
        case (size_i)
            SZ_HALF: swap_elem = lo_rev >> HSHIFT;
            SZ_WORD: swap_elem = lo_rev >> WSHIFT;
            default: swap_elem = lo_rev;
        endcase
        elem = brev_i ? swap_elem : lo_dw;
    end

    ldf_extend #(.W(XLEN)) u_ext (
        .elem_i(elem),
        .size_i(size_i),
        .sign_i(alg_i & ~brev_i),
        .val_o (ext_val)
    );

    always_comb begin
        res_d         = '0;
        res_d.illegal = illegal;
        if (!illegal) begin
            if (size_i == SZ_QUAD) begin
                res_d.even = le_mode_i ? lo_rev : hi_dw;
                res_d.odd  = le_mode_i ? hi_rev : lo_dw;
            end else begin
                res_d.even = ext_val;
            end
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (res_q == $past(res_d)));
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign res_even_o = res_q.even;
    assign res_odd_o  = res_q.odd;
    assign illegal_o  = res_q.illegal;

    assert_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE && !alg_i && !brev_i)
        |-> (res_d.even[XLEN-1:8] == '0 && res_d.even[7:0] == mem_data_i[7:0]));

    assert_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_WORD && alg_i && !brev_i)
        |-> (res_d.even[XLEN-1:32] == {(XLEN-32){mem_data_i[31]}}));

    assert_half_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_HALF && brev_i && !alg_i)
        |-> (res_d.even == {{(XLEN-16){1'b0}}, mem_data_i[7:0], mem_data_i[15:8]}));

    assert_quad_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_QUAD && !alg_i && !brev_i && !le_mode_i)
        |-> (res_d.even == mem_data_i[QW-1:XLEN] && res_d.odd == mem_data_i[XLEN-1:0]));

    assert_quad_le_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_QUAD && !alg_i && !brev_i && le_mode_i)
        |-> (res_d.even[XLEN-1 -: 8] == mem_data_i[7:0]
             && res_d.odd[XLEN-1 -: 8] == mem_data_i[XLEN+7:XLEN]));

    assert_odd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i != SZ_QUAD) |-> (res_d.odd == '0));

    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.illegal |-> (res_d.even == '0 && res_d.odd == '0));
endmodule

// File: tb/ldf_load_shaper_tb.sv
module ldf_load_shaper_tb;
    typedef struct packed {
        logic [127:0] mem;
        logic [2:0]   sz;
        logic         alg;
        logic         brev;
        logic         le;
        logic [63:0]  ee;
        logic [63:0]  eo;
        logic         ei;
        logic [3:0]   req;
    } vec_t;

    localparam logic [127:0] M1 = 128'h0011223344556677_8899AABBCCDDEEFF;
    localparam logic [127:0] M2 = 128'hFEDCBA9876543210_0123456789AB7F10;
    localparam int NV = 24;

    localparam vec_t VECS [NV] = '{
        '{M1, 3'd0, 1'b0, 1'b0, 1'b0, 64'h00000000000000FF, 64'h0, 1'b0, 4'd1},  // R1
        '{M1, 3'd1, 1'b0, 1'b0, 1'b0, 64'h000000000000EEFF, 64'h0, 1'b0, 4'd1},  // R1
        '{M1, 3'd2, 1'b0, 1'b0, 1'b0, 64'h00000000CCDDEEFF, 64'h0, 1'b0, 4'd1},  // R1
        '{M1, 3'd1, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFEEFF, 64'h0, 1'b0, 4'd2},  // R2
        '{M1, 3'd2, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFCCDDEEFF, 64'h0, 1'b0, 4'd2},  // R2
        '{M1, 3'd3, 1'b0, 1'b0, 1'b0, 64'h8899AABBCCDDEEFF, 64'h0, 1'b0, 4'd3},  // R3
        '{M1, 3'd1, 1'b0, 1'b1, 1'b0, 64'h000000000000FFEE, 64'h0, 1'b0, 4'd4},  // R4
        '{M1, 3'd2, 1'b0, 1'b1, 1'b0, 64'h00000000FFEEDDCC, 64'h0, 1'b0, 4'd5},  // R5
        '{M1, 3'd3, 1'b0, 1'b1, 1'b0, 64'hFFEEDDCCBBAA9988, 64'h0, 1'b0, 4'd6},  // R6
        '{M1, 3'd4, 1'b0, 1'b0, 1'b0, 64'h0011223344556677, 64'h8899AABBCCDDEEFF, 1'b0, 4'd7}, // R7
        '{M1, 3'd4, 1'b0, 1'b0, 1'b1, 64'hFFEEDDCCBBAA9988, 64'h7766554433221100, 1'b0, 4'd8}, // R8
        '{M1, 3'd2, 1'b0, 1'b0, 1'b1, 64'h00000000CCDDEEFF, 64'h0, 1'b0, 4'd9},  // R9
        '{M1, 3'd0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M1, 3'd1, 1'b1, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M1, 3'd4, 1'b0, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M1, 3'd0, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M1, 3'd3, 1'b1, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M1, 3'd5, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10},                 // R10
        '{M2, 3'd1, 1'b1, 1'b0, 1'b0, 64'h0000000000007F10, 64'h0, 1'b0, 4'd2},  // R2
        '{M2, 3'd2, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFF89AB7F10, 64'h0, 1'b0, 4'd2},  // R2
        '{M2, 3'd2, 1'b0, 1'b0, 1'b0, 64'h0000000089AB7F10, 64'h0, 1'b0, 4'd1},  // R1
        '{M2, 3'd0, 1'b0, 1'b0, 1'b1, 64'h0000000000000010, 64'h0, 1'b0, 4'd9},  // R9
        '{M2, 3'd4, 1'b0, 1'b0, 1'b1, 64'h107FAB8967452301, 64'h1032547698BADCFE, 1'b0, 4'd8}, // R8
        '{M2, 3'd1, 1'b0, 1'b1, 1'b0, 64'h000000000000107F, 64'h0, 1'b0, 4'd4}   // R4
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] mem_data;
    logic [2:0]   size;
    logic         alg, brev, le_mode;
    logic [63:0]  r_even, r_odd, c_even, c_odd;
    logic         r_ill, c_ill;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    ldf_load_shaper #(.OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_data_i(mem_data), .size_i(size),
        .alg_i(alg), .brev_i(brev), .le_mode_i(le_mode),
        .res_even_o(r_even), .res_odd_o(r_odd), .illegal_o(r_ill)
    );

    ldf_load_shaper #(.OUT_REG(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .mem_data_i(mem_data), .size_i(size),
        .alg_i(alg), .brev_i(brev), .le_mode_i(le_mode),
        .res_even_o(c_even), .res_odd_o(c_odd), .illegal_o(c_ill)
    );

    task automatic check(input string tag, input logic [63:0] ae, input logic [63:0] ao,
                         input logic ai, input logic [63:0] ee, input logic [63:0] eo,
                         input logic ei);
        n_chk++;
        if (ae !== ee || ao !== eo || ai !== ei) begin
            n_bad++;
            $display("FAIL %s actual even=%h odd=%h ill=%b expected even=%h odd=%h ill=%b",
                     tag, ae, ao, ai, ee, eo, ei);
        end
    endtask

    task automatic drive(input vec_t v);
        mem_data = v.mem;
        size     = v.sz;
        alg      = v.alg;
        brev     = v.brev;
        le_mode  = v.le;
    endtask

    initial begin
        // R11: registered outputs stay cleared during reset despite busy inputs
        drive(VECS[9]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset state", r_even, r_odd, r_ill, 64'h0, 64'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check($sformatf("R%0d comb vector %0d", VECS[i].req, i),
                  c_even, c_odd, c_ill, VECS[i].ee, VECS[i].eo, VECS[i].ei);
            @(posedge clk);
            #1;
            check($sformatf("R%0d reg vector %0d", VECS[i].req, i),
                  r_even, r_odd, r_ill, VECS[i].ee, VECS[i].eo, VECS[i].ei);
        end

        // R11: new inputs do not reach the registered outputs before the edge
        @(negedge clk);
        drive(VECS[10]);
        #1;
        check("R11 before edge", r_even, r_odd, r_ill,
              VECS[NV-1].ee, VECS[NV-1].eo, VECS[NV-1].ei);
        @(posedge clk);
        #1;
        check("R11 after edge", r_even, r_odd, r_ill, VECS[10].ee, VECS[10].eo, VECS[10].ei);

        // R11: asynchronous clear in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 mid-run reset", r_even, r_odd, r_ill, 64'h0, 64'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 actual expired expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule